// File: doc/BRIEF.md
# Edge-Latched Byte Memory Emulator

This block is a clocked model of a 2048-location, byte-wide static memory that has its own address latch. It sits behind a set of asynchronous, active-low strobes: a chip-select, a write strobe and a read (output) enable. A fast system clock samples those strobes. The block captures the address when it sees chip-select fall. It then either returns the addressed byte or commits a new byte to it. Its output is split into a data bus and a drive-enable, so an external tri-state pad can be built around it.

Each strobe passes through two flip-flops before any edge is detected. The returned byte is held back for a configurable number of clocks to stand in for access time. A write commits when the write strobe or chip-select rises, whichever comes first. The block also raises sticky warnings for three things: a possible bus fight, a chip-select high phase that is too short, and a chip-select low phase that is too short. These warnings can be used by a pin-level host or by a testbench that drives the block as its target.

Top module: `edge_latch_sram`

## Requirements
- R1: The array holds 2048 bytes at an 11-bit address. A byte committed at one location is read back unchanged from that location, and a write to one location leaves the other locations unchanged (this includes locations 0x000 and 0x7FF).
- R2: The address is captured on the 3rd rising clock edge after `sel_n_i` falls. Changing `addr_i` after that edge, while chip-select stays low, does not change which location the cycle reads or writes.
- R3: `drive_o` is a registered output. It is high only when the synchronised `sel_n_i` is 0, the synchronised `rd_n_i` is 0 and the synchronised `wr_n_i` is 1. After those inputs change, `drive_o` follows on the 3rd rising edge.
- R4: When `sel_n_i` rises, `drive_o` is low after the 3rd rising edge.
- R5: A write commits to the captured address on the 3rd rising edge after `wr_n_i` or `sel_n_i` rises, whichever is seen first. The byte stored is the value of `din_i` at that edge. Once the write strobe has risen, a later chip-select rise in the same cycle commits nothing.
- R6: If `wr_n_i` is held at 0 across several chip-select cycles, each chip-select rise commits one byte, to the address captured for that cycle.
- R7: `valid_o` is high only while `drive_o` is high and at least ACCESS_CLKS rising edges have passed since the address capture. `dout_o` is 0x00 whenever `valid_o` is 0.
- R8: `conflict_o` is set when the synchronised `wr_n_i` is seen falling while `drive_o` is high. It stays set until reset.
- R9: `short_high_o` is set, and stays set until reset, when `sel_n_i` falls after being high for fewer than MIN_HIGH_CLKS clocks. The first fall after reset never sets it.
- R10: `short_low_o` is set, and stays set until reset, when `sel_n_i` rises after being low for fewer than MIN_LOW_CLKS clocks.
- R11: During reset and right after it, `drive_o`, `valid_o`, `conflict_o`, `short_high_o` and `short_low_o` are 0, and `dout_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Chip-select strobe, active low, asynchronous |
| wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| rd_n_i | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | ADDR_W | Location address, captured when chip-select falls |
| din_i | input | DATA_W | Write data, sampled at the commit edge |
| dout_o | output | DATA_W | Read data; 0x00 while not valid |
| drive_o | output | 1 | Enable for the external tri-state buffer |
| valid_o | output | 1 | Read data is past its access delay |
| conflict_o | output | 1 | Sticky warning: write strobe fell while the outputs were driving |
| short_high_o | output | 1 | Sticky warning: chip-select high phase too short |
| short_low_o | output | 1 | Sticky warning: chip-select low phase too short |

## Verification
A wrong captured address appears as the wrong byte on `dout_o`. It shows in the first read after `valid_o` rises, which is ACCESS_CLKS edges after the capture. A wrong address in a write shows up later, only when that location is read back. A commit fired at the wrong strobe edge, or with stale data, appears as a mismatch in the read that follows. A stuck cycle flag appears at once as `drive_o` staying high three edges after chip-select rises. Miscounted width guards and miscounted access counters show on their flags within one chip-select cycle.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

  // Lane order of the strobe synchroniser; edge lanes come first.
  localparam int unsigned LANE_SEL = 0;
  localparam int unsigned LANE_WR  = 1;
  localparam int unsigned LANE_OE  = 2;

  // Bits needed to count up to lim (at least one bit).
  function automatic int unsigned cnt_bits(int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  // Saturating increment.
  function automatic int unsigned sat_bump(int unsigned cur, int unsigned lim);
    return (cur < lim) ? cur + 1 : cur;
  endfunction

  // True when an observed phase length is under its minimum.
  function automatic logic below_min(int unsigned seen, int unsigned lim);
    return seen < lim;
  endfunction

endpackage

// File: rtl/sram_strobe_sync.sv
module sram_strobe_sync #(
  parameter int unsigned LANES      = 3,
  parameter int unsigned EDGE_LANES = 2,
  parameter logic [LANES-1:0] IDLE  = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      raw_i,
  output logic [LANES-1:0]      lvl_o,
  output logic [EDGE_LANES-1:0] rise_o,
  output logic [EDGE_LANES-1:0] fall_o
);
  logic [LANES-1:0]      meta_q;
  logic [LANES-1:0]      sync_q;
  logic [EDGE_LANES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE;
      sync_q <= IDLE;
      prev_q <= IDLE[EDGE_LANES-1:0];
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q[EDGE_LANES-1:0];
    end
  end

  assign lvl_o = sync_q;

  for (genvar g = 0; g < EDGE_LANES; g++) begin : g_edge
    assign rise_o[g] =  sync_q[g] & ~prev_q[g];
    assign fall_o[g] = ~sync_q[g] &  prev_q[g];
  end
endmodule

// File: rtl/sram_width_guard.sv
module sram_width_guard
  import sram_emu_pkg::*;
#(
  parameter int unsigned MIN_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic start_i,
  input  logic end_i,
  output logic short_o
);
  localparam int unsigned CW = cnt_bits(MIN_CLKS);

  logic [CW-1:0] seen_q;
  logic          short_q;

  // Starts saturated so that the first phase after reset is exempt.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= CW'(MIN_CLKS);
      short_q <= 1'b0;
    end else begin
      if (start_i)      seen_q <= CW'(1);
      else if (level_i) seen_q <= CW'(sat_bump(32'(seen_q), MIN_CLKS));
      if (end_i && below_min(32'(seen_q), MIN_CLKS)) short_q <= 1'b1;
    end
  end

  assign short_o = short_q;
endmodule

// File: rtl/sram_mem_core.sv
module sram_mem_core #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[addr_i] <= wdata_i;
  end

  assign rdata_o = cells[addr_i];
endmodule

// File: rtl/edge_latch_sram.sv
module edge_latch_sram
  import sram_emu_pkg::*;
#(
  parameter int unsigned ADDR_W        = 11,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned ACCESS_CLKS   = 3,
  parameter int unsigned MIN_HIGH_CLKS = 4,
  parameter int unsigned MIN_LOW_CLKS  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              wr_n_i,
  input  logic              rd_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              drive_o,
  output logic              valid_o,
  output logic              conflict_o,
  output logic              short_high_o,
  output logic              short_low_o
);
  localparam int unsigned AC_W = cnt_bits(ACCESS_CLKS);

  // Synchronised strobe levels and edge events.
  logic [2:0] strobe_lvl;
  logic [1:0] strobe_rise;
  logic [1:0] strobe_fall;

  sram_strobe_sync #(.LANES(3), .EDGE_LANES(2), .IDLE(3'b111)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({rd_n_i, wr_n_i, sel_n_i}),
    .lvl_o  (strobe_lvl),
    .rise_o (strobe_rise),
    .fall_o (strobe_fall)
  );

  logic sel_lvl, wr_lvl, oe_lvl;
  logic sel_fall_ev, sel_rise_ev, wr_rise_ev, wr_fall_ev;
  assign sel_lvl     = strobe_lvl[LANE_SEL];
  assign wr_lvl      = strobe_lvl[LANE_WR];
  assign oe_lvl      = strobe_lvl[LANE_OE];
  assign sel_fall_ev = strobe_fall[LANE_SEL];
  assign sel_rise_ev = strobe_rise[LANE_SEL];
  assign wr_rise_ev  = strobe_rise[LANE_WR];
  assign wr_fall_ev  = strobe_fall[LANE_WR];

  // Cycle state.
  logic              cycle_on;
  logic              drive_q;
  logic              conflict_q;
  logic [ADDR_W-1:0] lat_addr;
  logic [AC_W-1:0]   acc_cnt;

  logic cycle_next, show_next, wr_commit, access_done;

  always_comb begin
    cycle_next  = (cycle_on | sel_fall_ev) & ~sel_rise_ev;
    show_next   = cycle_next & ~sel_lvl & ~oe_lvl & wr_lvl;
    wr_commit   = cycle_on & (wr_rise_ev | (sel_rise_ev & ~wr_lvl));
    access_done = (acc_cnt == AC_W'(ACCESS_CLKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_on   <= 1'b0;
      drive_q    <= 1'b0;
      conflict_q <= 1'b0;
      lat_addr   <= '0;
      acc_cnt    <= '0;
    end else begin
      cycle_on   <= cycle_next;
      drive_q    <= show_next;
      conflict_q <= conflict_q | (wr_fall_ev & drive_q);
      if (sel_fall_ev) begin
        lat_addr <= addr_i;
        acc_cnt  <= '0;
      end else if (cycle_on) begin
        acc_cnt  <= AC_W'(sat_bump(32'(acc_cnt), ACCESS_CLKS));
      end
    end
  end

  logic [DATA_W-1:0] rd_data;

  sram_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .we_i    (wr_commit),
    .addr_i  (lat_addr),
    .wdata_i (din_i),
    .rdata_o (rd_data)
  );

  // Phase-width guards on chip-select.
  sram_width_guard #(.MIN_CLKS(MIN_HIGH_CLKS)) u_high_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (sel_lvl),
    .start_i (sel_rise_ev),
    .end_i   (sel_fall_ev),
    .short_o (short_high_o)
  );

  sram_width_guard #(.MIN_CLKS(MIN_LOW_CLKS)) u_low_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (~sel_lvl),
    .start_i (sel_fall_ev),
    .end_i   (sel_rise_ev),
    .short_o (short_low_o)
  );

  assign drive_o    = drive_q;
  assign valid_o    = drive_q & access_done;
  assign dout_o     = valid_o ? rd_data : '0;
  assign conflict_o = conflict_q;
endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk #(
  parameter int unsigned AW  = 11,
  parameter int unsigned DW  = 8,
  parameter int unsigned ACC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_fall_ev,
  input logic          sel_rise_ev,
  input logic          wr_rise_ev,
  input logic          cycle_on,
  input logic          wr_commit,
  input logic [AW-1:0] lat_addr,
  input logic          drive_o,
  input logic          valid_o,
  input logic [DW-1:0] dout_o,
  input logic          conflict_o,
  input logic          short_high_o,
  input logic          short_low_o
);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_on && !sel_fall_ev) |=> $stable(lat_addr));

  p_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise_ev |=> !drive_o);

  p_commit_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (cycle_on && (wr_rise_ev || sel_rise_ev)));

  if (ACC > 0) begin : g_acc
    p_no_early_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fall_ev |=> (!valid_o && dout_o == '0));
  end

  p_conflict_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |=> conflict_o);

  p_high_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    short_high_o |=> short_high_o);

  p_low_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    short_low_o |=> short_low_o);
endmodule

bind edge_latch_sram sram_emu_chk #(.AW(ADDR_W), .DW(DATA_W), .ACC(ACCESS_CLKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_fall_ev  (sel_fall_ev),
  .sel_rise_ev  (sel_rise_ev),
  .wr_rise_ev   (wr_rise_ev),
  .cycle_on     (cycle_on),
  .wr_commit    (wr_commit),
  .lat_addr     (lat_addr),
  .drive_o      (drive_o),
  .valid_o      (valid_o),
  .dout_o       (dout_o),
  .conflict_o   (conflict_o),
  .short_high_o (short_high_o),
  .short_low_o  (short_low_o)
);

// File: tb/tb_edge_latch_sram.sv
`timescale 1ns/1ps
module tb_edge_latch_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        drive, valid, conflict, short_high, short_low;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [7:0] mdl [2048];

  always #5 clk = ~clk;

  edge_latch_sram dut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .wr_n_i(wr_n), .rd_n_i(rd_n),
    .addr_i(addr), .din_i(din), .dout_o(dout), .drive_o(drive), .valid_o(valid),
    .conflict_o(conflict), .short_high_o(short_high), .short_low_o(short_low)
  );

  // {write, write-strobe-first, addr[10:0], data[7:0]}
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 1'b1, 11'h000, 8'hA5},
    {1'b1, 1'b0, 11'h7FF, 8'h3C},
    {1'b1, 1'b1, 11'h155, 8'h96},
    {1'b0, 1'b0, 11'h000, 8'h00},
    {1'b0, 1'b0, 11'h7FF, 8'h00},
    {1'b1, 1'b0, 11'h000, 8'h5A},
    {1'b0, 1'b0, 11'h000, 8'h00},
    {1'b0, 1'b0, 11'h155, 8'h00}
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    waitn(3);
    rst_n = 1'b1;
    waitn(2);
  endtask

  // Write cycle: commit at the 3rd edge after the first strobe rise.
  task automatic write_cycle(logic [10:0] a, logic [7:0] d, bit wfirst);
    @(negedge clk);
    addr = a; din = d; rd_n = 1'b1; sel_n = 1'b0; wr_n = 1'b0;
    waitn(3);
    addr = ~a;                                  // R2: ignored after capture
    chk("R3 no drive during write", {7'd0, drive}, 8'd0);
    chk("R8 no conflict in plain write", {7'd0, conflict}, 8'd0);
    waitn(3);
    if (wfirst) wr_n = 1'b1; else sel_n = 1'b1;
    waitn(3);
    din = ~d;                                   // R5: past the commit edge
    if (wfirst) sel_n = 1'b1; else wr_n = 1'b1;
    waitn(4);
    mdl[a] = d;
  endtask

  task automatic read_cycle(logic [10:0] a, logic [7:0] exp);
    @(negedge clk);
    addr = a; wr_n = 1'b1; rd_n = 1'b0; sel_n = 1'b0;
    waitn(3);
    chk("R3 drive on 3rd edge", {7'd0, drive}, 8'd1);
    chk("R7 not valid before access", {7'd0, valid}, 8'd0);
    addr = ~a;                                  // R2
    waitn(2);
    chk("R7 still not valid", {7'd0, valid}, 8'd0);
    chk("R7 dout zero while not valid", dout, 8'h00);
    waitn(1);
    chk("R7 valid after access", {7'd0, valid}, 8'd1);
    chk("R1 R2 read data", dout, exp);
    sel_n = 1'b1;
    waitn(3);
    chk("R4 drive off after select rise", {7'd0, drive}, 8'd0);
    rd_n = 1'b1;
    waitn(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    waitn(2);
    chk("R11 drive in reset", {7'd0, drive}, 8'd0);
    rst_n = 1'b1;
    waitn(2);
    chk("R11 valid", {7'd0, valid}, 8'd0);
    chk("R11 dout", dout, 8'h00);
    chk("R11 flags", {5'd0, conflict, short_high, short_low}, 8'd0);

    // Vector walk: R1 R2 R5
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][20]) write_cycle(VEC[i][18:8], VEC[i][7:0], VEC[i][19]);
      else            read_cycle(VEC[i][18:8], mdl[VEC[i][18:8]]);
    end

    // R6: write strobe held low across three chip-select cycles
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      addr = 11'h100 + 11'(k); din = 8'h10 + 8'(k); sel_n = 1'b0;
      waitn(3);
      addr = 11'h2AA;
      waitn(3);
      sel_n = 1'b1;
      waitn(3);
      din = 8'hEE;
      waitn(2);
      mdl[11'h100 + 11'(k)] = 8'h10 + 8'(k);
    end
    wr_n = 1'b1;
    waitn(2);
    for (int k = 0; k < 3; k++) read_cycle(11'h100 + 11'(k), 8'h10 + 8'(k));
    read_cycle(11'h7FF, mdl[11'h7FF]);          // R1: neighbour untouched
    chk("R9 R10 no width flag in legal traffic", {6'd0, short_high, short_low}, 8'd0);

    // R8: write strobe falls while driving
    @(negedge clk);
    addr = 11'h0F0; din = 8'hC3; wr_n = 1'b1; rd_n = 1'b0; sel_n = 1'b0;
    waitn(4);
    wr_n = 1'b0;
    waitn(4);
    chk("R8 conflict set", {7'd0, conflict}, 8'd1);
    wr_n = 1'b1;
    waitn(3);
    sel_n = 1'b1; rd_n = 1'b1;
    waitn(4);
    chk("R8 conflict sticky", {7'd0, conflict}, 8'd1);
    read_cycle(11'h0F0, 8'hC3);                 // R5: write strobe rise committed

    // R10: chip-select low for 2 clocks
    do_reset();
    @(negedge clk); sel_n = 1'b0;
    waitn(2); sel_n = 1'b1;
    waitn(4);
    chk("R10 short low flagged", {7'd0, short_low}, 8'd1);
    chk("R9 high untouched", {7'd0, short_high}, 8'd0);

    // R9: chip-select high for 2 clocks between legal low phases
    do_reset();
    chk("R11 flags cleared", {6'd0, short_high, short_low}, 8'd0);
    @(negedge clk); sel_n = 1'b0;
    waitn(7); sel_n = 1'b1;
    waitn(2); sel_n = 1'b0;
    waitn(7); sel_n = 1'b1;
    waitn(4);
    chk("R9 short high flagged", {7'd0, short_high}, 8'd1);
    chk("R10 low untouched", {7'd0, short_low}, 8'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule